// File: doc/BRIEF.md
# Pseudo-Random Test Sequencing Controller

This block sequences a self-test experiment. Two 8-bit linear-feedback pattern generators feed a stand-in device under test. The two 8-bit results of that stand-in are folded into two signature compressors. A 10-bit cycle counter records how many test cycles have been applied. Its two top bits choose the operating mode of the device under test. When the counter reaches its terminal value of 1023 the sequence is complete, and the `done` flag freezes everything that advances.

Software or a button front end supplies single-cycle pulses. Two load pulses seed the generators from parallel inputs. A step pulse applies one test cycle. A run pulse latches a free-running mode that stays on until reset. The generators, compressors and stub are simple behavioural models, so the controller can be exercised on its own.

Top module: `bist_sequencer`

## Requirements
- R1: A synchronous active-high `rst` sets the cycle count to 0, clears the latched run mode, sets both pattern generators to 8'h01 and both signatures to 8'h00.
- R2: `cycle_cnt` rises by exactly 1 at each clock edge where `adv_en` is high, and holds otherwise. It never wraps past 1023.
- R3: `done` is high exactly when `cycle_cnt` equals 1023 (10'h3FF).
- R4: `adv_en` equals (`step` OR latched run mode) AND NOT `done`.
- R5: A `run` pulse sets the latched run mode from the next clock edge. Only `rst` clears it, so later steps or run pulses leave it set.
- R6: `mode_sel` equals `cycle_cnt[9:8]`.
- R7: A `load_a` (`load_b`) pulse places `iva` (`ivb`) in pattern A (B) at the next edge. A load overrides an advance in the same cycle. `load_a_str` and `load_b_str` echo the load pulses.
- R8: On `adv_en`, each pattern generator takes next = {p[6:0], p[7]^p[5]^p[4]^p[3]}, which is a period-255 sequence. Without an advance or a load the pattern holds.
- R9: `sig_qual` is high exactly when `cycle_cnt` is nonzero.
- R10: A signature register updates only at edges where both `adv_en` and `sig_qual` are high. Its next value is {s[6:0], ^(s & 8'hB8)} XOR d, where d is the stub result it receives. Otherwise it holds.
- R11: The stub results (x, y) depend on `mode_sel`, with 8-bit wraparound: 0 gives (a+b, a^b); 1 gives (a-b, a&b); 2 gives (a|b, ~a); 3 gives (a with its nibbles swapped, b+1). Here a and b are the current patterns.
- R12: While `done` is high, step pulses and the run mode change neither the count, nor the patterns, nor the signatures. From a count of 0 in run mode, exactly 1023 advances occur before `done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_a | input | 1 | Pulse: seed pattern A from iva |
| load_b | input | 1 | Pulse: seed pattern B from ivb |
| step | input | 1 | Pulse: apply one test cycle |
| run | input | 1 | Pulse: enter free-running mode |
| iva | input | 8 | Seed value for pattern A |
| ivb | input | 8 | Seed value for pattern B |
| load_a_str | output | 1 | Load strobe to pattern A |
| load_b_str | output | 1 | Load strobe to pattern B |
| adv_en | output | 1 | Common advance enable |
| mode_sel | output | 2 | Operating mode of the device under test |
| sig_qual | output | 1 | Signature-enable qualifier (count nonzero) |
| done | output | 1 | Terminal count reached |
| cycle_cnt | output | 10 | Applied test cycle count |
| pat_a | output | 8 | Pattern generator A state |
| pat_b | output | 8 | Pattern generator B state |
| sig_x | output | 8 | Signature of the stub's x result |
| sig_y | output | 8 | Signature of the stub's y result |

## Verification
`adv_en`, `done`, `mode_sel` and `sig_qual` are combinational. They are due in the same cycle as the stimulus or count that forms them. The count, the run latch, the patterns and the signatures are due one clock edge after the pulse or advance that moves them. A run pulse therefore first shows up as an advance in the cycle after it is applied. The bench drives inputs just after a falling edge and compares all outputs against its reference model 1 ns later. It then moves the model state on the rising edge, so each comparison lines up with exactly one register stage.

// File: rtl/bist_pkg.sv
package bist_pkg;
  localparam int PAT_W = 8;
  localparam int CNT_W = 10;
  localparam logic [PAT_W-1:0] FB_MASK  = 8'hB8;
  localparam logic [PAT_W-1:0] SIG_MASK = 8'hB8;

  typedef enum logic [1:0] {
    MODE_ADD = 2'd0,
    MODE_SUB = 2'd1,
    MODE_LOG = 2'd2,
    MODE_ROT = 2'd3
  } mode_e;

  function automatic logic [PAT_W-1:0] prng_next(input logic [PAT_W-1:0] p,
                                                 input logic [PAT_W-1:0] mask);
    return {p[PAT_W-2:0], ^(p & mask)};
  endfunction

  function automatic logic [PAT_W-1:0] sig_next(input logic [PAT_W-1:0] s,
                                                input logic [PAT_W-1:0] d,
                                                input logic [PAT_W-1:0] mask);
    return {s[PAT_W-2:0], ^(s & mask)} ^ d;
  endfunction

  function automatic logic [2*PAT_W-1:0] stub_eval(input mode_e m,
                                                   input logic [PAT_W-1:0] a,
                                                   input logic [PAT_W-1:0] b);
    logic [PAT_W-1:0] x, y;
    case (m)
      MODE_ADD: begin x = a + b;                  y = a ^ b;    end
      MODE_SUB: begin x = a - b;                  y = a & b;    end
      MODE_LOG: begin x = a | b;                  y = ~a;       end
      default:  begin x = {a[3:0], a[7:4]};       y = b + 8'd1; end
    endcase
    return {x, y};
  endfunction
endpackage

// File: rtl/prng_gen.sv
module prng_gen #(
  parameter int W = bist_pkg::PAT_W,
  parameter logic [W-1:0] MASK = bist_pkg::FB_MASK,
  parameter logic [W-1:0] SEED = 8'h01
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         adv,
  input  logic [W-1:0] seed_in,
  output logic [W-1:0] q
);
  logic [W-1:0] stepped;
  assign stepped = bist_pkg::prng_next(q, MASK);

  always_ff @(posedge clk) begin
    if (rst)       q <= SEED;
    else if (load) q <= seed_in;
    else if (adv)  q <= stepped;
  end

  assert_load_wins_R7: assert property (@(posedge clk) disable iff (rst)
    load |=> q == $past(seed_in));
  assert_hold_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv) |=> $stable(q));
endmodule

// File: rtl/sig_comp.sv
module sig_comp #(
  parameter int W = bist_pkg::PAT_W,
  parameter logic [W-1:0] MASK = bist_pkg::SIG_MASK
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] s
);
  always_ff @(posedge clk) begin
    if (rst)     s <= '0;
    else if (en) s <= bist_pkg::sig_next(s, d, MASK);
  end

  assert_sig_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(s));
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl #(
  parameter int KW = bist_pkg::CNT_W,
  localparam logic [KW-1:0] K_LAST = {KW{1'b1}}
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          run,
  output logic [KW-1:0] k,
  output logic          adv,
  output logic          done,
  output logic          cnz
);
  logic run_q;
  logic at_last;

  assign at_last = (k == K_LAST);
  assign done    = at_last;
  assign cnz     = |k;
  assign adv     = (step | run_q) & ~at_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      k     <= '0;
    end else begin
      if (run) run_q <= 1'b1;
      if (adv) k <= k + KW'(1);
    end
  end

  assert_k_step_R2: assert property (@(posedge clk) disable iff (rst)
    adv |=> k == $past(k) + KW'(1));
  assert_k_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(k));
  assert_no_wrap_R12: assert property (@(posedge clk) disable iff (rst)
    done |=> done);
  assert_run_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    run_q |=> run_q);
  assert_run_sets_R5: assert property (@(posedge clk) disable iff (rst)
    run |=> run_q);
  assert_frozen_R12: assert property (@(posedge clk) disable iff (rst)
    done |-> !adv);
endmodule

// File: rtl/bist_sequencer.sv
module bist_sequencer #(
  parameter int W  = bist_pkg::PAT_W,
  parameter int KW = bist_pkg::CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_a,
  input  logic          load_b,
  input  logic          step,
  input  logic          run,
  input  logic [W-1:0]  iva,
  input  logic [W-1:0]  ivb,
  output logic          load_a_str,
  output logic          load_b_str,
  output logic          adv_en,
  output logic [1:0]    mode_sel,
  output logic          sig_qual,
  output logic          done,
  output logic [KW-1:0] cycle_cnt,
  output logic [W-1:0]  pat_a,
  output logic [W-1:0]  pat_b,
  output logic [W-1:0]  sig_x,
  output logic [W-1:0]  sig_y
);
  import bist_pkg::*;

  logic [KW-1:0]  k;
  logic           adv, fin, nz, sig_en;
  logic [W-1:0]   pa, pb;
  logic [2*W-1:0] stub_xy;
  logic [W-1:0]   stub_x, stub_y;
  logic [W-1:0]   seeds [2];
  logic           loads [2];
  logic [W-1:0]   pats  [2];
  logic [W-1:0]   sigs  [2];
  logic [W-1:0]   ds    [2];

  seq_ctrl #(.KW(KW)) u_ctrl (
    .clk(clk), .rst(rst), .step(step), .run(run),
    .k(k), .adv(adv), .done(fin), .cnz(nz)
  );

  assign seeds[0] = iva;
  assign seeds[1] = ivb;
  assign loads[0] = load_a;
  assign loads[1] = load_b;

  genvar g;
  generate
    for (g = 0; g < 2; g++) begin : g_pair
      prng_gen #(.W(W)) u_gen (
        .clk(clk), .rst(rst), .load(loads[g]), .adv(adv),
        .seed_in(seeds[g]), .q(pats[g])
      );
      sig_comp #(.W(W)) u_sig (
        .clk(clk), .rst(rst), .en(sig_en), .d(ds[g]), .s(sigs[g])
      );
    end
  endgenerate

  assign pa      = pats[0];
  assign pb      = pats[1];
  assign stub_xy = stub_eval(mode_e'(k[KW-1 -: 2]), pa, pb);
  assign stub_x  = stub_xy[2*W-1:W];
  assign stub_y  = stub_xy[W-1:0];
  assign ds[0]   = stub_x;
  assign ds[1]   = stub_y;
  assign sig_en  = adv & nz;

  assign load_a_str = load_a;
  assign load_b_str = load_b;
  assign adv_en     = adv;
  assign mode_sel   = k[KW-1 -: 2];
  assign sig_qual   = nz;
  assign done       = fin;
  assign cycle_cnt  = k;
  assign pat_a      = pa;
  assign pat_b      = pb;
  assign sig_x      = sigs[0];
  assign sig_y      = sigs[1];

  assert_sig_gate_R9: assert property (@(posedge clk) disable iff (rst)
    (k == '0) |=> $stable(sig_x) && $stable(sig_y));
  assert_pat_frozen_R12: assert property (@(posedge clk) disable iff (rst)
    (fin && !load_a && !load_b) |=> $stable(pa) && $stable(pb));
endmodule

// File: tb/tb_bist_sequencer.sv
`timescale 1ns/1ps
module tb_bist_sequencer;
  logic clk = 1'b0;
  logic rst, load_a, load_b, step, run;
  logic [7:0] iva, ivb;
  logic load_a_str, load_b_str, adv_en, sig_qual, done;
  logic [1:0] mode_sel;
  logic [9:0] cycle_cnt;
  logic [7:0] pat_a, pat_b, sig_x, sig_y;

  always #2.5 clk = ~clk;

  bist_sequencer dut (.*);

  int vectors = 0, errors = 0, adv_seen = 0;
  int mk, mrun, mpa, mpb, msx, msy;

  function automatic int lfsr_ref(int p);
    int fb = ((p >> 7) ^ (p >> 5) ^ (p >> 4) ^ (p >> 3)) & 1;
    return ((p << 1) & 255) | fb;
  endfunction

  function automatic int misr_ref(int s, int d);
    int par = 0;
    for (int i = 0; i < 8; i++) if (((8'hB8 >> i) & 1) != 0) par ^= (s >> i) & 1;
    return (((s << 1) & 255) | par) ^ d;
  endfunction

  function automatic int stub_ref(int sel, int a, int b, int which);
    int x, y;
    if (sel == 0)      begin x = a + b;                           y = a ^ b; end
    else if (sel == 1) begin x = a - b + 256;                     y = a & b; end
    else if (sel == 2) begin x = a | b;                           y = 255 - a; end
    else               begin x = ((a % 16) * 16) + (a / 16);      y = b + 1; end
    return (which == 0 ? x : y) % 256;
  endfunction

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (k=%0d)", tag, act, exp, mk);
    end
  endtask

  task automatic cyc(bit r, bit la, bit lb, bit st, bit rn, int a, int b);
    int e_done, e_adv, e_nz, e_sel, nx, ny;
    rst = r; load_a = la; load_b = lb; step = st; run = rn;
    iva = 8'(a); ivb = 8'(b);
    #1;
    e_done = (mk == 1023);
    e_adv  = ((st || mrun != 0) && e_done == 0) ? 1 : 0;
    e_nz   = (mk != 0);
    e_sel  = mk / 256;
    if (!r) begin
      chk("R2 cycle_cnt", int'(cycle_cnt), mk);
      chk("R3 done", int'(done), e_done);
      chk("R4 adv_en", int'(adv_en), e_adv);
      chk("R6 mode_sel", int'(mode_sel), e_sel);
      chk("R9 sig_qual", int'(sig_qual), e_nz);
      chk("R7 load strobes", int'({load_a_str, load_b_str}), int'({la, lb}));
      chk("R8 pat_a", int'(pat_a), mpa);
      chk("R8 pat_b", int'(pat_b), mpb);
      chk("R10 sig_x", int'(sig_x), msx);
      chk("R10 sig_y", int'(sig_y), msy);
      if (adv_en) adv_seen++;
    end
    @(posedge clk);
    if (r) begin
      mk = 0; mrun = 0; mpa = 1; mpb = 1; msx = 0; msy = 0;
    end else begin
      nx = stub_ref(e_sel, mpa, mpb, 0);
      ny = stub_ref(e_sel, mpa, mpb, 1);
      if (e_adv != 0 && e_nz != 0) begin   // R11 stub results feed R10
        msx = misr_ref(msx, nx);
        msy = misr_ref(msy, ny);
      end
      if (la) mpa = a; else if (e_adv != 0) mpa = lfsr_ref(mpa);
      if (lb) mpb = b; else if (e_adv != 0) mpb = lfsr_ref(mpb);
      if (e_adv != 0) mk++;
      if (rn) mrun = 1;
    end
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    mk = 0; mrun = 0; mpa = 1; mpb = 1; msx = 0; msy = 0;
    rst = 1; load_a = 0; load_b = 0; step = 0; run = 0; iva = 0; ivb = 0;
    @(negedge clk);
    repeat (3) cyc(1, 0, 0, 0, 0, 0, 0);
    // R1: reset state
    cyc(0, 0, 0, 0, 0, 0, 0);
    chk("R1 reset count", int'(cycle_cnt), 0);
    chk("R1 reset pattern", int'(pat_a), 1);
    // R7 loads
    cyc(0, 1, 1, 0, 0, 8'h5A, 8'hC3);
    cyc(0, 0, 0, 0, 0, 0, 0);
    chk("R7 pat_a seeded", int'(pat_a), 8'h5A);
    // R8 steps, idle gaps, and load overriding advance (R7)
    for (int i = 0; i < 6; i++) begin
      cyc(0, 0, 0, 1, 0, 0, 0);
      cyc(0, 0, 0, 0, 0, 0, 0);
    end
    cyc(0, 1, 0, 1, 0, 8'h81, 0);
    cyc(0, 0, 0, 0, 0, 0, 0);
    chk("R7 load beats advance", int'(pat_a), 8'h81);
    for (int i = 0; i < 20; i++) cyc(0, 0, 0, 1, 0, 0, 0);
    // R5 / R12: free run from count 0 to terminal count
    cyc(1, 0, 0, 0, 0, 0, 0);
    cyc(0, 1, 1, 0, 0, 8'h3C, 8'hE7);
    adv_seen = 0;
    cyc(0, 0, 0, 0, 1, 0, 0);
    chk("R5 run latched", int'(adv_en), 1);
    for (int i = 0; i < 1100 && !done; i++) cyc(0, 0, 0, i % 7 == 3, i % 97 == 5, 0, 0);
    chk("R12 advances before done", adv_seen, 1023);
    chk("R3 done at 1023", int'(done), 1);
    // R12: frozen after done
    for (int i = 0; i < 10; i++) cyc(0, 0, 0, 1, i == 4, 0, 0);
    chk("R12 count frozen", int'(cycle_cnt), 1023);
    // R1: reset clears run mode
    cyc(1, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0, 0);
    chk("R5 run cleared by reset", int'(cycle_cnt), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule